// File: doc/BRIEF.md
# Floating-Point Divide Special-Case Resolver

This combinational block sits in front of a floating-point divider. It receives the class and sign of both unpacked operands, the dividend and the divisor. Each class is one of zero, normal, infinity, quiet NaN or signalling NaN. It decides whether the mantissa divider has to run or whether the answer is already fixed by the operand classes.

When the result is fixed, the block gives the result class and sign. It also says whether the payload is taken from the dividend, taken from the divisor, or built as a default NaN. It raises an exception flag for each distinct cause:
- a signalling NaN operand;
- infinity divided by infinity;
- zero divided by zero;
- division of a finite nonzero number by zero.

The mantissa quotient and rounding are done downstream and are not part of this block.

The cases are resolved in a fixed priority order:
1. any NaN operand;
2. an infinite dividend;
3. a zero dividend;
4. an infinite divisor;
5. a zero divisor;
6. the true divide.

Top module: `fpdiv_special_resolve`

## Requirements
- R1: Class codes are 3 bits: zero=000, normal=001, infinity=010, signalling NaN=100, quiet NaN=110. When either operand is a NaN, the result class is quiet NaN (110). The forwarded operand is the divisor unless the dividend is the only NaN, or the dividend is signalling and the divisor is quiet. In those two cases the dividend is forwarded. The result sign is the sign of the forwarded operand. Forward select codes: 00 = none (default NaN or built value), 01 = dividend, 10 = divisor.
- R2: The signalling-NaN invalid flag is high exactly when at least one operand is a signalling NaN.
- R3: Infinity divided by infinity gives a default NaN and raises the infinity/infinity invalid flag. A default NaN is class 110, sign 0, forward select 00.
- R4: Infinity divided by zero or by a normal number gives infinity. The sign is the dividend's own sign, and the forward select is 01.
- R5: Zero divided by zero gives a default NaN and raises the zero/zero invalid flag. The divide-by-zero flag stays low in this case.
- R6: Zero divided by a normal number or by infinity gives zero. The sign is the XOR of the operand signs, and the forward select is 01.
- R7: A normal number divided by infinity gives zero with the XOR sign and forward select 00.
- R8: A normal number divided by zero gives infinity with the XOR sign and forward select 00, and raises the divide-by-zero flag.
- R9: The start-divide output is high only for normal divided by normal. That case also reports class normal (001), the XOR sign and forward select 00. The outputs follow the inputs with no clock.
- R10: Every flag not named above for a given class pair is low, so at most one of the four flags is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dvd_cls_i | input | 3 | Dividend class code |
| dvd_sign_i | input | 1 | Dividend sign |
| dvs_cls_i | input | 3 | Divisor class code |
| dvs_sign_i | input | 1 | Divisor sign |
| res_cls_o | output | 3 | Result class code |
| res_sign_o | output | 1 | Result sign |
| fwd_sel_o | output | 2 | Payload source: 00 none, 01 dividend, 10 divisor |
| inv_snan_o | output | 1 | Invalid: signalling NaN operand |
| inv_inf_inf_o | output | 1 | Invalid: infinity divided by infinity |
| inv_zero_zero_o | output | 1 | Invalid: zero divided by zero |
| div_by_zero_o | output | 1 | Finite nonzero divided by zero |
| start_div_o | output | 1 | Launch the mantissa divider |

## Verification
Every one of the 25 ordered class pairs is applied with all four sign combinations, so the bench sees 100 patterns in total.

The class pairs separate the priority steps. NaN against infinity or zero shows the NaN rule beats the other rules, and infinity over zero shows the infinite-dividend rule beats the zero-divisor rule. The NaN pairs taken in both operand orders show which operand is forwarded.

The sign combinations separate three sign rules: the dividend's own sign for infinite-dividend results, the XOR of the operand signs, and the forwarded NaN's sign.

A directed sequence changes the divisor between normal and zero without a clock edge. It confirms that start-divide and the divide-by-zero flag switch on the input change alone.

// File: rtl/fpdiv_sc_pkg.sv
// Package: shared class codes, forward-select codes and the decoded class
// record for the divide special-case resolver.
// Assumes: operands arrive already unpacked into a class code and a sign.
package fpdiv_sc_pkg;
    localparam int CLS_W = 3;
    localparam int SEL_W = 2;
    localparam int N_OPS = 2;

    typedef enum logic [CLS_W-1:0] {
        FC_ZERO = 3'b000,
        FC_NORM = 3'b001,
        FC_INF  = 3'b010,
        FC_SNAN = 3'b100,
        FC_QNAN = 3'b110
    } fcls_e;

    typedef enum logic [SEL_W-1:0] {
        FWD_NONE = 2'b00,
        FWD_DVD  = 2'b01,
        FWD_DVS  = 2'b10
    } fwd_e;

    typedef struct packed {
        logic zero;
        logic norm;
        logic inf;
        logic nan;
        logic snan;
    } cls_dec_t;
endpackage

// File: rtl/fpdiv_sc_classify.sv
// Module: decodes one operand class code into one-hot style predicates.
// Assumes: the code is one of the five legal values; bit 2 marks a NaN and
// bit 1 then separates quiet (1) from signalling (0).
module fpdiv_sc_classify
    import fpdiv_sc_pkg::*;
(
    input  logic [CLS_W-1:0] cls_code,
    output cls_dec_t         dec
);
    // Turn the raw code into the predicates the decision logic needs.
    always_comb begin
        dec.zero = (cls_code == FC_ZERO);
        dec.norm = (cls_code == FC_NORM);
        dec.inf  = (cls_code == FC_INF);
        dec.nan  = cls_code[2];
        dec.snan = cls_code[2] & ~cls_code[1];
    end

    // Flag any code outside the legal set.
    always_comb begin
        if (!$isunknown(cls_code)) begin
            // R1
            legal_code_chk: assert (cls_code == FC_ZERO || cls_code == FC_NORM ||
                                    cls_code == FC_INF  || cls_code == FC_SNAN ||
                                    cls_code == FC_QNAN)
                else $error("illegal class code %b", cls_code);
        end
    end
endmodule

// File: rtl/fpdiv_sc_decide.sv
// Module: priority resolution of divide special cases.
// Order: NaN, infinite dividend, zero dividend, infinite divisor, zero
// divisor, then the true divide.
// Assumes: decoded inputs from fpdiv_sc_classify.
module fpdiv_sc_decide
    import fpdiv_sc_pkg::*;
#(
    parameter logic DFLT_NAN_SIGN = 1'b0
) (
    input  cls_dec_t         dvd,
    input  cls_dec_t         dvs,
    input  logic             dvd_sign,
    input  logic             dvs_sign,
    output logic [CLS_W-1:0] res_cls,
    output logic             res_sign,
    output logic [SEL_W-1:0] fwd_sel,
    output logic             inv_snan,
    output logic             inv_inf_inf,
    output logic             inv_zero_zero,
    output logic             div_by_zero,
    output logic             start_div
);
    logic sign_xor;
    logic pick_dvd_nan;

    // Sign used by all results after the NaN and infinite-dividend steps.
    assign sign_xor = dvd_sign ^ dvs_sign;

    // Forward the dividend NaN only if it is the sole NaN or the sole signalling one.
    assign pick_dvd_nan = dvd.nan & (~dvs.nan | (dvd.snan & ~dvs.snan));

    // Walk the special-case priority chain and set every output.
    always_comb begin
        res_cls       = FC_NORM;
        res_sign      = sign_xor;
        fwd_sel       = FWD_NONE;
        inv_snan      = 1'b0;
        inv_inf_inf   = 1'b0;
        inv_zero_zero = 1'b0;
        div_by_zero   = 1'b0;
        start_div     = 1'b0;
        if (dvd.nan | dvs.nan) begin
            res_cls  = FC_QNAN;
            inv_snan = dvd.snan | dvs.snan;
            if (pick_dvd_nan) begin
                fwd_sel  = FWD_DVD;
                res_sign = dvd_sign;
            end else begin
                fwd_sel  = FWD_DVS;
                res_sign = dvs_sign;
            end
        end else if (dvd.inf) begin
            if (dvs.inf) begin
                res_cls     = FC_QNAN;
                res_sign    = DFLT_NAN_SIGN;
                inv_inf_inf = 1'b1;
            end else begin
                res_cls  = FC_INF;
                res_sign = dvd_sign;
                fwd_sel  = FWD_DVD;
            end
        end else if (dvd.zero) begin
            if (dvs.zero) begin
                res_cls       = FC_QNAN;
                res_sign      = DFLT_NAN_SIGN;
                inv_zero_zero = 1'b1;
            end else begin
                res_cls = FC_ZERO;
                fwd_sel = FWD_DVD;
            end
        end else if (dvs.inf) begin
            res_cls = FC_ZERO;
        end else if (dvs.zero) begin
            res_cls     = FC_INF;
            div_by_zero = 1'b1;
        end else begin
            start_div = 1'b1;
        end
    end

    // Cross-check outputs against operand classes.
    always_comb begin
        if (!$isunknown({dvd, dvs, dvd_sign, dvs_sign})) begin
            // R10
            flag_excl_chk: assert ($onehot0({inv_snan, inv_inf_inf, inv_zero_zero, div_by_zero}))
                else $error("more than one exception flag");
            // R9
            start_norm_chk: assert (!start_div || (dvd.norm && dvs.norm))
                else $error("divider started on a special operand");
            // R8
            dz_inf_chk: assert (!div_by_zero || (res_cls == FC_INF && dvs.zero))
                else $error("divide-by-zero without infinite result");
            // R3
            dflt_nan_chk: assert (!(res_cls == FC_QNAN && fwd_sel == FWD_NONE) ||
                                  (res_sign == DFLT_NAN_SIGN && (inv_inf_inf || inv_zero_zero)))
                else $error("default NaN malformed");
            // R1
            nan_fwd_chk: assert (!(dvd.nan || dvs.nan) || fwd_sel != FWD_NONE)
                else $error("NaN operand not forwarded");
        end
    end
endmodule

// File: rtl/fpdiv_special_resolve.sv
// Module: top of the divide special-case resolver. Decodes both operand
// classes and resolves the fixed result or the start of the divider.
// Assumes: purely combinational use; no clock or reset.
module fpdiv_special_resolve
    import fpdiv_sc_pkg::*;
#(
    parameter logic DFLT_NAN_SIGN = 1'b0
) (
    input  logic [2:0] dvd_cls_i,
    input  logic       dvd_sign_i,
    input  logic [2:0] dvs_cls_i,
    input  logic       dvs_sign_i,
    output logic [2:0] res_cls_o,
    output logic       res_sign_o,
    output logic [1:0] fwd_sel_o,
    output logic       inv_snan_o,
    output logic       inv_inf_inf_o,
    output logic       inv_zero_zero_o,
    output logic       div_by_zero_o,
    output logic       start_div_o
);
    logic [CLS_W-1:0] op_cls [N_OPS];
    cls_dec_t         op_dec [N_OPS];

    // Gather the two operand codes; index 0 dividend, 1 divisor.
    assign op_cls[0] = dvd_cls_i;
    assign op_cls[1] = dvs_cls_i;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fpdiv_sc_classify u_cls (
            .cls_code (op_cls[g]),
            .dec      (op_dec[g])
        );
    end

    fpdiv_sc_decide #(
        .DFLT_NAN_SIGN (DFLT_NAN_SIGN)
    ) u_decide (
        .dvd           (op_dec[0]),
        .dvs           (op_dec[1]),
        .dvd_sign      (dvd_sign_i),
        .dvs_sign      (dvs_sign_i),
        .res_cls       (res_cls_o),
        .res_sign      (res_sign_o),
        .fwd_sel       (fwd_sel_o),
        .inv_snan      (inv_snan_o),
        .inv_inf_inf   (inv_inf_inf_o),
        .inv_zero_zero (inv_zero_zero_o),
        .div_by_zero   (div_by_zero_o),
        .start_div     (start_div_o)
    );
endmodule

// File: tb/fpdiv_special_resolve_tb.sv
`timescale 1ns/1ps
// Bench: table of class pairs with expected results, walked over all sign
// combinations, then directed checks on combinational response.
module fpdiv_special_resolve_tb_top;
    localparam logic [2:0] Z = 3'b000, N = 3'b001, I = 3'b010, S = 3'b100, Q = 3'b110;
    // Sign modes: 0 xor, 1 dividend, 2 divisor, 3 default (0)
    typedef struct packed {
        logic [2:0] a;
        logic [2:0] b;
        logic [2:0] rc;
        logic [1:0] sm;
        logic [1:0] sel;
        logic [3:0] flg; // {snan, inf_inf, zero_zero, div_by_zero}
        logic       st;
        logic [3:0] req;
    } vec_t;

    localparam vec_t TBL [25] = '{
        '{Z, Z, Q, 2'd3, 2'b00, 4'b0010, 1'b0, 4'd5},  // R5
        '{Z, N, Z, 2'd0, 2'b01, 4'b0000, 1'b0, 4'd6},  // R6
        '{Z, I, Z, 2'd0, 2'b01, 4'b0000, 1'b0, 4'd6},  // R6
        '{Z, Q, Q, 2'd2, 2'b10, 4'b0000, 1'b0, 4'd1},  // R1
        '{Z, S, Q, 2'd2, 2'b10, 4'b1000, 1'b0, 4'd2},  // R2
        '{N, Z, I, 2'd0, 2'b00, 4'b0001, 1'b0, 4'd8},  // R8
        '{N, N, N, 2'd0, 2'b00, 4'b0000, 1'b1, 4'd9},  // R9
        '{N, I, Z, 2'd0, 2'b00, 4'b0000, 1'b0, 4'd7},  // R7
        '{N, Q, Q, 2'd2, 2'b10, 4'b0000, 1'b0, 4'd1},  // R1
        '{N, S, Q, 2'd2, 2'b10, 4'b1000, 1'b0, 4'd2},  // R2
        '{I, Z, I, 2'd1, 2'b01, 4'b0000, 1'b0, 4'd4},  // R4
        '{I, N, I, 2'd1, 2'b01, 4'b0000, 1'b0, 4'd4},  // R4
        '{I, I, Q, 2'd3, 2'b00, 4'b0100, 1'b0, 4'd3},  // R3
        '{I, Q, Q, 2'd2, 2'b10, 4'b0000, 1'b0, 4'd1},  // R1
        '{I, S, Q, 2'd2, 2'b10, 4'b1000, 1'b0, 4'd2},  // R2
        '{Q, Z, Q, 2'd1, 2'b01, 4'b0000, 1'b0, 4'd1},  // R1
        '{Q, N, Q, 2'd1, 2'b01, 4'b0000, 1'b0, 4'd1},  // R1
        '{Q, I, Q, 2'd1, 2'b01, 4'b0000, 1'b0, 4'd1},  // R1
        '{Q, Q, Q, 2'd2, 2'b10, 4'b0000, 1'b0, 4'd1},  // R1
        '{Q, S, Q, 2'd2, 2'b10, 4'b1000, 1'b0, 4'd2},  // R2
        '{S, Z, Q, 2'd1, 2'b01, 4'b1000, 1'b0, 4'd2},  // R2
        '{S, N, Q, 2'd1, 2'b01, 4'b1000, 1'b0, 4'd2},  // R2
        '{S, I, Q, 2'd1, 2'b01, 4'b1000, 1'b0, 4'd2},  // R2
        '{S, Q, Q, 2'd1, 2'b01, 4'b1000, 1'b0, 4'd2},  // R2
        '{S, S, Q, 2'd2, 2'b10, 4'b1000, 1'b0, 4'd2}   // R2
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dvd_cls = 3'b000, dvs_cls = 3'b000;
    logic       dvd_sign = 1'b0, dvs_sign = 1'b0;
    logic [2:0] res_cls;
    logic       res_sign;
    logic [1:0] fwd_sel;
    logic       f_snan, f_ii, f_zz, f_dz, start_div;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    fpdiv_special_resolve dut_i (
        .dvd_cls_i       (dvd_cls),
        .dvd_sign_i      (dvd_sign),
        .dvs_cls_i       (dvs_cls),
        .dvs_sign_i      (dvs_sign),
        .res_cls_o       (res_cls),
        .res_sign_o      (res_sign),
        .fwd_sel_o       (fwd_sel),
        .inv_snan_o      (f_snan),
        .inv_inf_inf_o   (f_ii),
        .inv_zero_zero_o (f_zz),
        .div_by_zero_o   (f_dz),
        .start_div_o     (start_div)
    );

    // Compare packed actual against expected and report.
    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (cls,sign,sel,flags,start)", tag, act, exp);
        end
    endtask

    function automatic logic [12:0] outs();
        return {res_cls, res_sign, fwd_sel, f_snan, f_ii, f_zz, f_dz, start_div};
    endfunction

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Table walk over all 25 class pairs and four sign combinations.
        for (int i = 0; i < 25; i++) begin
            for (int s = 0; s < 4; s++) begin
                logic       es;
                logic [12:0] exp;
                @(posedge clk);
                dvd_cls  = TBL[i].a;
                dvs_cls  = TBL[i].b;
                dvd_sign = s[1];
                dvs_sign = s[0];
                case (TBL[i].sm)
                    2'd0:    es = s[1] ^ s[0];
                    2'd1:    es = s[1];
                    2'd2:    es = s[0];
                    default: es = 1'b0;
                endcase
                exp = {TBL[i].rc, es, TBL[i].sel, TBL[i].flg, TBL[i].st};
                #1;
                check($sformatf("R%0d pair %0d signs %0d", TBL[i].req, i, s), outs(), exp);
                // R10: at most one flag high
                check($sformatf("R10 flag count pair %0d", i),
                      13'($countones({f_snan, f_ii, f_zz, f_dz}) <= 1), 13'd1);
            end
        end
        // R9 directed: outputs follow inputs with no clock edge.
        @(negedge clk);
        dvd_cls = N; dvs_cls = N; dvd_sign = 1'b1; dvs_sign = 1'b0;
        #0.5;
        check("R9 live start", outs(), {N, 1'b1, 2'b00, 4'b0000, 1'b1});
        dvs_cls = Z;
        #0.5;
        check("R8 live divide by zero", outs(), {I, 1'b1, 2'b00, 4'b0001, 1'b0});
        dvd_cls = Z;
        #0.5;
        check("R5 live zero over zero", outs(), {Q, 1'b0, 2'b00, 4'b0010, 1'b0});
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule